// File: doc/BRIEF.md
# Split Address Translation Buffer

This block turns request addresses into physical memory addresses for two requesters that share one translation store: a processor and an I/O bus. The store has two regions of equal depth. The processor region is direct-mapped and tagged, and each of its entries carries a protection code. The I/O-bus region is direct-mapped with no tag. A processor reference can also be marked physical, and it then skips the store entirely. Each request gives a result one clock later. That result is a physical address, or one fault flag: a translation miss, an access violation, or an I/O map error. Walking page tables and reaching memory are left to the surrounding logic. That logic fills entries through a single-cycle write port.

Pages are 512 bytes. Address bits [8:0] are the byte offset and pass through untranslated. Bits [17:9] select the entry in whichever region the request uses. For processor virtual references, bits [31:18] are the tag. An invalidate-all pulse starts a small state machine with two states. In `CLR_IDLE` it waits. It leaves `CLR_IDLE` for `CLR_WALK` when `inv_all` is seen. In `CLR_WALK` it clears the valid bit of one index in both regions on every cycle. It returns from `CLR_WALK` to `CLR_IDLE` after it clears the last index. `busy` is high exactly while the machine is in `CLR_WALK`.

Top module: `split_xlat_buffer`

## Requirements
- R1: A request sampled with `req_valid` high produces `res_valid` high in the next cycle. With no request, `res_valid` is low in the next cycle.
- R2: A processor virtual reference (`req_io`=0, `req_phys`=0) that hits returns the physical address {stored frame, addr[8:0]}. It hits when the entry at addr[17:9] is valid and its stored tag equals addr[31:18].
- R3: A processor virtual reference raises `res_miss` when the selected entry is invalid or its tag differs. Whenever any fault flag is set, `res_pa` is zero.
- R4: The protection code is 4 bits. The current mode is 0 (most privileged) to 3. Reading is allowed when mode <= code[3:2]. Writing is allowed when mode <= code[1:0] and code[1:0] <= code[3:2]. A denied access on a tag hit raises `res_acv`. A miss takes priority, so `res_acv` is never raised together with `res_miss`.
- R5: A processor physical reference (`req_io`=0, `req_phys`=1) returns addr[29:0] as the physical address. It raises no fault flag, whatever the contents of the store.
- R6: An I/O-bus reference (`req_io`=1) uses only the I/O region at addr[17:9]. It does no tag check and never raises `res_miss` or `res_acv`. A valid entry returns {frame, addr[8:0]}. An invalid entry raises `res_maperr`. Fills to one region never change the other.
- R7: A fill writes one entry in one cycle and is seen by lookups from the next cycle on. A lookup in the same cycle as a fill to the same index returns the old contents.
- R8: An `inv_all` pulse sampled while idle makes `busy` high from the next cycle for exactly 512 cycles. After that, every entry in both regions is invalid. An `inv_all` pulse while `busy` is high has no effect on the length of the clear.
- R9: A fill presented while `busy` is high is ignored.
- R10: After reset, `res_valid` and `busy` are low and every entry in both regions is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request present |
| req_io | input | 1 | 1: I/O-bus reference, 0: processor reference |
| req_phys | input | 1 | Processor reference is physical (bypass) |
| req_mode | input | 2 | Current access mode, 0 most privileged |
| req_write | input | 1 | 1: write access, 0: read access |
| req_addr | input | 32 | Request address |
| fill_en | input | 1 | Write one entry |
| fill_io | input | 1 | 1: target I/O region, 0: processor region |
| fill_idx | input | 9 | Entry index |
| fill_valid | input | 1 | Valid bit to store |
| fill_tag | input | 14 | Tag (processor region only) |
| fill_prot | input | 4 | Protection code (processor region only) |
| fill_pfn | input | 21 | Physical frame number |
| inv_all | input | 1 | Start clearing all valid bits |
| busy | output | 1 | Clear in progress |
| res_valid | output | 1 | Result present |
| res_pa | output | 30 | Physical address |
| res_miss | output | 1 | Translation miss |
| res_acv | output | 1 | Access violation |
| res_maperr | output | 1 | I/O map entry invalid |

## Verification
Some rules hold on every cycle and the assertions watch them there. These are the one-cycle result timing, the mutual exclusion of fault flags, the zero address on a fault, the offset pass-through, the bypass of physical references, the absence of miss and violation on I/O references, and the exact length of the clear. Other properties depend on what is stored, so only the bench's scenarios can show them. These are the tag comparison, the protection table, the miss-over-violation order on real entries, the old-data return when a fill and a lookup hit the same index, the loss of valid bits after a clear, and the dropping of fills during a clear.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic {
        CLR_IDLE,
        CLR_WALK
    } clr_state_e;

    // Access rights derived from a 4-bit protection code: [3:2] is the least
    // privileged mode that may read, [1:0] the least privileged that may write.
    function automatic logic prot_permits(input logic [3:0] code,
                                          input logic [1:0] mode,
                                          input logic       wr);
        logic rd_ok;
        logic wr_ok;
        rd_ok = (mode <= code[3:2]);
        wr_ok = (mode <= code[1:0]) && (code[1:0] <= code[3:2]);
        return wr ? wr_ok : rd_ok;
    endfunction

endpackage

// File: rtl/xlat_region.sv
module xlat_region #(
    parameter int IDX_W  = 9,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] store [DEPTH];
    logic [DEPTH-1:0]  vbits;

    // Payload: no reset, read returns the contents before this edge's write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
        rd_data <= store[rd_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vbits    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= vbits[rd_idx];
            if (clr_en) begin
                vbits[clr_idx] <= 1'b0;
            end else if (wr_en) begin
                vbits[wr_idx] <= wr_valid;
            end
        end
    end
endmodule

// File: rtl/xlat_clear_seq.sv
module xlat_clear_seq
    import xlat_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic             clr_en,
    output logic [IDX_W-1:0] clr_idx
);
    localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

    clr_state_e       state, state_nx;
    logic [IDX_W-1:0] walk_idx;

    always_comb begin
        state_nx = state;
        unique case (state)
            CLR_IDLE: if (start)           state_nx = CLR_WALK;
            CLR_WALK: if (walk_idx == LAST) state_nx = CLR_IDLE;
            default:                        state_nx = CLR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CLR_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_idx <= '0;
        end else if (state == CLR_WALK) begin
            walk_idx <= walk_idx + 1'b1;
        end else begin
            walk_idx <= '0;
        end
    end

    always_comb begin
        busy    = 1'b0;
        clr_en  = 1'b0;
        clr_idx = walk_idx;
        unique case (state)
            CLR_IDLE: ;
            CLR_WALK: begin
                busy   = 1'b1;
                clr_en = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/split_xlat_buffer.sv
module split_xlat_buffer
    import xlat_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int PA_W  = 30,
    parameter int OFS_W = 9,
    parameter int IDX_W = 9,
    parameter int PROT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_valid,
    input  logic                          req_io,
    input  logic                          req_phys,
    input  logic [1:0]                    req_mode,
    input  logic                          req_write,
    input  logic [VA_W-1:0]               req_addr,
    input  logic                          fill_en,
    input  logic                          fill_io,
    input  logic [IDX_W-1:0]              fill_idx,
    input  logic                          fill_valid,
    input  logic [VA_W-OFS_W-IDX_W-1:0]   fill_tag,
    input  logic [PROT_W-1:0]             fill_prot,
    input  logic [PA_W-OFS_W-1:0]         fill_pfn,
    input  logic                          inv_all,
    output logic                          busy,
    output logic                          res_valid,
    output logic [PA_W-1:0]               res_pa,
    output logic                          res_miss,
    output logic                          res_acv,
    output logic                          res_maperr
);
    localparam int TAG_W  = VA_W - OFS_W - IDX_W;
    localparam int PFN_W  = PA_W - OFS_W;
    localparam int CPU_DW = TAG_W + PROT_W + PFN_W;

    logic             clr_en;
    logic [IDX_W-1:0] clr_idx;
    logic             fill_ok;
    logic [IDX_W-1:0] look_idx;

    logic              cpu_v, io_v;
    logic [CPU_DW-1:0] cpu_rd;
    logic [PFN_W-1:0]  io_rd;

    logic            q_valid, q_io, q_phys, q_write;
    logic [1:0]      q_mode;
    logic [VA_W-1:0] q_addr;

    logic [TAG_W-1:0]  cpu_tag;
    logic [PROT_W-1:0] cpu_prot;
    logic [PFN_W-1:0]  cpu_pfn;
    logic              tag_hit;

    assign fill_ok  = fill_en && !busy;
    assign look_idx = req_addr[OFS_W +: IDX_W];

    xlat_clear_seq #(.IDX_W(IDX_W)) u_clear (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (inv_all),
        .busy    (busy),
        .clr_en  (clr_en),
        .clr_idx (clr_idx)
    );

    xlat_region #(.IDX_W(IDX_W), .DATA_W(CPU_DW)) u_cpu_region (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_ok && !fill_io),
        .wr_idx   (fill_idx),
        .wr_valid (fill_valid),
        .wr_data  ({fill_tag, fill_prot, fill_pfn}),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .rd_idx   (look_idx),
        .rd_valid (cpu_v),
        .rd_data  (cpu_rd)
    );

    xlat_region #(.IDX_W(IDX_W), .DATA_W(PFN_W)) u_io_region (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (fill_ok && fill_io),
        .wr_idx   (fill_idx),
        .wr_valid (fill_valid),
        .wr_data  (fill_pfn),
        .clr_en   (clr_en),
        .clr_idx  (clr_idx),
        .rd_idx   (look_idx),
        .rd_valid (io_v),
        .rd_data  (io_rd)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_io    <= 1'b0;
            q_phys  <= 1'b0;
            q_write <= 1'b0;
            q_mode  <= '0;
            q_addr  <= '0;
        end else begin
            q_valid <= req_valid;
            q_io    <= req_io;
            q_phys  <= req_phys;
            q_write <= req_write;
            q_mode  <= req_mode;
            q_addr  <= req_addr;
        end
    end

    assign {cpu_tag, cpu_prot, cpu_pfn} = cpu_rd;
    assign tag_hit = cpu_v && (cpu_tag == q_addr[VA_W-1 -: TAG_W]);

    always_comb begin
        res_valid  = q_valid;
        res_pa     = '0;
        res_miss   = 1'b0;
        res_acv    = 1'b0;
        res_maperr = 1'b0;
        if (q_valid) begin
            if (q_io) begin
                if (io_v) res_pa = {io_rd, q_addr[OFS_W-1:0]};
                else      res_maperr = 1'b1;
            end else if (q_phys) begin
                res_pa = q_addr[PA_W-1:0];
            end else if (!tag_hit) begin
                res_miss = 1'b1;
            end else if (!prot_permits(cpu_prot, q_mode, q_write)) begin
                res_acv = 1'b1;
            end else begin
                res_pa = {cpu_pfn, q_addr[OFS_W-1:0]};
            end
        end
    end
endmodule

// File: rtl/xlat_checker.sv
module xlat_checker #(
    parameter int VA_W  = 32,
    parameter int PA_W  = 30,
    parameter int OFS_W = 9,
    parameter int IDX_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_io,
    input logic            req_phys,
    input logic [VA_W-1:0] req_addr,
    input logic            inv_all,
    input logic            busy,
    input logic            res_valid,
    input logic [PA_W-1:0] res_pa,
    input logic            res_miss,
    input logic            res_acv,
    input logic            res_maperr
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W:0] busy_run;
    logic           fault;

    assign fault = res_miss || res_acv || res_maperr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_run <= '0;
        else        busy_run <= busy ? busy_run + 1'b1 : '0;
    end

    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);                                         // R1
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);                                       // R1
    AST_ONE_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({res_miss, res_acv, res_maperr}) <= 1);                // R4
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> res_pa == '0);                                          // R3
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (fault || res_pa[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]))); // R2
    AST_PHYS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_io && req_phys) |=>
            (!fault && res_pa == $past(req_addr[PA_W-1:0])));             // R5
    AST_IO_NEVER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_io) |=> (!res_miss && !res_acv));               // R6
    AST_CPU_NO_MAPERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_io) |=> !res_maperr);                          // R6
    AST_CLEAR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> busy_run < DEPTH);                                       // R8
    AST_CLEAR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_run == DEPTH);                               // R8
    AST_CLEAR_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(inv_all));                                  // R8
endmodule

bind split_xlat_buffer xlat_checker #(
    .VA_W(VA_W), .PA_W(PA_W), .OFS_W(OFS_W), .IDX_W(IDX_W)
) u_xlat_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io),
    .req_phys(req_phys), .req_addr(req_addr), .inv_all(inv_all),
    .busy(busy), .res_valid(res_valid), .res_pa(res_pa),
    .res_miss(res_miss), .res_acv(res_acv), .res_maperr(res_maperr)
);

// File: tb/split_xlat_buffer_test.sv
module split_xlat_buffer_test;
    localparam int DEPTH = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 0, req_io = 0, req_phys = 0, req_write = 0;
    logic [1:0]  req_mode = 0;
    logic [31:0] req_addr = 0;
    logic        fill_en = 0, fill_io = 0, fill_valid = 0, inv_all = 0;
    logic [8:0]  fill_idx = 0;
    logic [13:0] fill_tag = 0;
    logic [3:0]  fill_prot = 0;
    logic [20:0] fill_pfn = 0;
    logic        busy, res_valid, res_miss, res_acv, res_maperr;
    logic [29:0] res_pa;

    // Reference model
    logic        m_cv [DEPTH];
    logic [13:0] m_ctag [DEPTH];
    logic [3:0]  m_cprot [DEPTH];
    logic [20:0] m_cpfn [DEPTH];
    logic        m_iv [DEPTH];
    logic [20:0] m_ipfn [DEPTH];

    logic        e_valid, e_miss, e_acv, e_map;
    logic [29:0] e_pa;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4ns clk = ~clk;

    split_xlat_buffer uut (.*);

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic allowed(input logic [3:0] p, input logic [1:0] m,
                                     input logic w);
        if (w) return (m <= p[1:0]) && (p[1:0] <= p[3:2]);
        return m <= p[3:2];
    endfunction

    // Expected result for the request currently on the inputs (model before fill).
    task automatic predict();
        int idx;
        idx = int'(req_addr[17:9]);
        e_valid = req_valid; e_pa = '0; e_miss = 0; e_acv = 0; e_map = 0;
        if (!req_valid) return;
        if (req_io) begin
            if (m_iv[idx]) e_pa = {m_ipfn[idx], req_addr[8:0]};
            else e_map = 1;
        end else if (req_phys) begin
            e_pa = req_addr[29:0];
        end else if (!m_cv[idx] || m_ctag[idx] != req_addr[31:18]) begin
            e_miss = 1;
        end else if (!allowed(m_cprot[idx], req_mode, req_write)) begin
            e_acv = 1;
        end else begin
            e_pa = {m_cpfn[idx], req_addr[8:0]};
        end
    endtask

    task automatic model_fill();
        int i;
        i = int'(fill_idx);
        if (!fill_en) return;
        if (fill_io) begin
            m_iv[i] = fill_valid; m_ipfn[i] = fill_pfn;
        end else begin
            m_cv[i] = fill_valid; m_ctag[i] = fill_tag;
            m_cprot[i] = fill_prot; m_cpfn[i] = fill_pfn;
        end
    endtask

    // Inputs are set at a falling edge; results checked at the next falling edge.
    task automatic step_and_check(input string req);
        predict();
        model_fill();
        @(posedge clk);
        @(negedge clk);
        check(req, "res_valid", res_valid, e_valid);
        check(req, "res_pa", res_pa, e_pa);
        check(req, "res_miss", res_miss, e_miss);
        check(req, "res_acv", res_acv, e_acv);
        check(req, "res_maperr", res_maperr, e_map);
        fill_en = 0; req_valid = 0;
    endtask

    task automatic set_req(input logic io, input logic ph, input logic [1:0] md,
                           input logic wr, input logic [31:0] a);
        req_valid = 1; req_io = io; req_phys = ph; req_mode = md;
        req_write = wr; req_addr = a;
    endtask

    task automatic set_fill(input logic io, input int idx, input logic v,
                            input logic [13:0] t, input logic [3:0] p,
                            input logic [20:0] f);
        fill_en = 1; fill_io = io; fill_idx = 9'(idx); fill_valid = v;
        fill_tag = t; fill_prot = p; fill_pfn = f;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int busy_len;
        void'($urandom(32'd1234));
        for (int i = 0; i < DEPTH; i++) begin
            m_cv[i] = 0; m_iv[i] = 0; m_ctag[i] = 0; m_cprot[i] = 0;
            m_cpfn[i] = 0; m_ipfn[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10: reset state
        check("R10", "res_valid", res_valid, 0);
        check("R10", "busy", busy, 0);
        set_req(0, 0, 0, 0, 32'h0001_2345);
        step_and_check("R10");
        set_req(1, 0, 0, 0, 32'h0003_0A11);
        step_and_check("R10");

        // R7: fill and lookup on same index in same cycle return old contents
        set_fill(0, 3, 1, 14'h0055, 4'hF, 21'h1ABCD);
        set_req(0, 0, 0, 0, {14'h0055, 9'd3, 9'h07F});
        step_and_check("R7");
        set_req(0, 0, 0, 0, {14'h0055, 9'd3, 9'h07F});
        step_and_check("R2");
        // R3: tag mismatch and R4 miss priority over denied protection
        set_fill(0, 4, 1, 14'h0011, 4'b0000, 21'h00777);
        step_and_check("R7");
        set_req(0, 0, 3, 1, {14'h0012, 9'd4, 9'h001});
        step_and_check("R3");
        set_req(0, 0, 3, 1, {14'h0011, 9'd4, 9'h001});
        step_and_check("R4");
        set_req(0, 0, 0, 0, {14'h0011, 9'd4, 9'h1FF});
        step_and_check("R4");
        // R5: physical bypass with an invalid entry at that index
        set_req(0, 1, 3, 1, 32'hFFFF_FFFF);
        step_and_check("R5");
        // R6: I/O region separate from CPU region
        set_req(1, 0, 0, 0, {14'h0055, 9'd3, 9'h07F});
        step_and_check("R6");
        set_fill(1, 3, 1, 14'h3FFF, 4'h0, 21'h0F0F0);
        step_and_check("R6");
        set_req(1, 0, 3, 1, {14'h2222, 9'd3, 9'h100});
        step_and_check("R6");

        // Random mixed traffic: R1..R7
        for (int n = 0; n < 4000; n++) begin
            int sel;
            if ($urandom_range(0, 2) != 0)
                set_fill($urandom_range(0, 1), $urandom_range(0, 7),
                         $urandom_range(0, 3) != 0, 14'($urandom_range(0, 2)),
                         4'($urandom), 21'($urandom));
            if ($urandom_range(0, 4) != 0) begin
                sel = $urandom_range(0, 5);
                set_req(sel == 0, sel == 1, 2'($urandom), 1'($urandom),
                        {14'($urandom_range(0, 2)), 9'($urandom_range(0, 7)),
                         9'($urandom)});
                if (sel == 1) req_addr = $urandom;
            end
            step_and_check(sel == 0 ? "R6" : (sel == 1 ? "R5" : "R1"));
        end

        // R8 / R9: invalidate-all with a fill and a second pulse during the clear
        set_fill(0, 0, 1, 14'h0001, 4'hF, 21'h00001);
        step_and_check("R7");
        set_fill(1, 0, 1, 14'h0000, 4'h0, 21'h00002);
        step_and_check("R7");
        inv_all = 1;
        @(posedge clk); @(negedge clk);
        inv_all = 0;
        busy_len = 0;
        while (busy && busy_len < 2000) begin
            if (busy_len == 10) set_fill(0, 0, 1, 14'h0001, 4'hF, 21'h00003);
            if (busy_len == 20) inv_all = 1;
            @(posedge clk); @(negedge clk);
            fill_en = 0; inv_all = 0;
            busy_len++;
        end
        check("R8", "busy cycles", busy_len, DEPTH);
        for (int i = 0; i < DEPTH; i++) begin m_cv[i] = 0; m_iv[i] = 0; end
        set_req(0, 0, 0, 0, {14'h0001, 9'd0, 9'h000});
        step_and_check("R9");
        set_req(1, 0, 0, 0, {14'h0000, 9'd0, 9'h000});
        step_and_check("R8");
        set_req(0, 0, 0, 0, {14'h0055, 9'd3, 9'h07F});
        step_and_check("R8");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule